// File: doc/BRIEF.md
# Clock Loss Detector with Automatic Failover

This block monitors a fast main clock against a slower, always-available backup oscillator. When the main clock stops toggling, the block moves the system clock over to the backup oscillator. When the main clock has been running steadily again for long enough, the block moves it back. Neither direction needs software. Each change of source goes through a glitch-free multiplexer, so the system clock never carries a truncated high or low phase.

A sticky loss flag records that the backup source has been in use. Software clears it by writing one, but only after the main clock is back in charge. The flag drives an interrupt request, gated by a configuration enable bit and a global mask. While the device is in its wait state, that request also produces a wake signal. In halt the detector is switched off and raises nothing. Its stored configuration survives a halt, and a reset sets it back to the defaults.

All control and status logic runs in the backup clock domain. The main clock reaches that domain only as a synchronized toggle.

Top module: `clk_failover`

## Requirements
- R1: With detection enabled and halt low, once the main clock stops, `on_backup` goes to 1 no later than 20 backup cycles afterwards. It is still 0 six backup cycles afterwards, because loss is declared only after LOSS_CYC = 8 backup cycles pass with no detected main transition.
- R2: After the main clock restarts, `on_backup` returns to 0 with no software action once REC_EDGES = 16 consecutive main transitions have been detected with no timeout. It therefore stays 1 for at least 12 backup cycles after the restart, and it is 0 within 50.
- R3: `loss_flag` becomes 1 one backup cycle after `on_backup` is 1. It stays 1 until it is cleared.
- R4: When `flag_clr` is high at a backup rising edge and `on_backup` was 0 before that edge, `loss_flag` is cleared. While `on_backup` is 1, `flag_clr` has no effect.
- R5: `irq` equals `loss_flag` AND the stored interrupt enable AND NOT `irq_mask` AND NOT `halt_mode`. It is combinational in the same cycle.
- R6: `wake` equals `irq` AND `wait_mode`.
- R7: While `halt_mode` is 1, the detector is off. Stopping the main clock then leaves `on_backup` at 0, and `irq` and `wake` stay 0.
- R8: A `cfg_wr` pulse at a backup edge loads `cfg_det_en` and `cfg_irq_en`. The stored values survive halt. Reset returns them to detection on and interrupt off.
- R9: With detection disabled, a stopped main clock never moves `on_backup` to 1.
- R10: `clk_sys` follows the selected source, with the same number of rising edges over a window (±1). It never has a high or low phase shorter than the shorter half-period of the two sources.
- R11: Main clock bursts that are too short to reach 16 detected transitions, separated by timeouts, keep `on_backup` at 1.
- R12: Reset (synchronous, active high, in the backup domain) gives `on_backup` = 0, `loss_flag` = 0 and `irq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_main | input | 1 | Main clock being monitored |
| clk_bak | input | 1 | Low-frequency backup oscillator; clocks all control logic |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load strobe for the configuration bits |
| cfg_det_en | input | 1 | Detection enable value to store |
| cfg_irq_en | input | 1 | Interrupt enable value to store |
| irq_mask | input | 1 | Global interrupt mask, 1 = masked |
| halt_mode | input | 1 | Device in halt; detector off |
| wait_mode | input | 1 | Device in wait |
| flag_clr | input | 1 | Write-one-to-clear for the loss flag |
| clk_sys | output | 1 | Selected system clock |
| on_backup | output | 1 | 1 while the backup source is selected |
| loss_flag | output | 1 | Sticky flag showing that the backup has been active |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Request to leave wait |

## Verification
`irq` and `wake` are combinational and are due in the same cycle as their inputs. `loss_flag` is due one backup cycle after `on_backup`. The bench's per-cycle model reproduces exactly these latencies and compares every backup cycle at the falling edge. A switch to backup depends on synchronizer stages and the timeout count, and a return depends on when the bench's main clock happens to be sampled. Both are therefore checked inside windows: an early bound that the required count makes impossible to beat, and a late bound sized above the worst case. Clock quality is checked at the output pin, by measuring every `clk_sys` phase and by comparing edge counts against the selected source.

// File: rtl/clkfo_pkg.sv
`timescale 1ns/1ps
package clkfo_pkg;

    localparam int unsigned LOSS_CYC_DEF  = 8;
    localparam int unsigned REC_EDGES_DEF = 16;
    localparam int unsigned MAIN_DIV_DEF  = 1;
    localparam int unsigned SYNC_DEF      = 2;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_BAK  = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic det_en;
        logic irq_en;
    } clkfo_cfg_t;

    localparam clkfo_cfg_t CFG_RESET = '{det_en: 1'b1, irq_en: 1'b0};

    typedef struct packed {
        logic lost;
        logic healthy;
    } watch_stat_t;

    function automatic logic irq_gate(input clkfo_cfg_t c, input logic flag,
                                      input logic mask, input logic halt);
        return flag & c.irq_en & ~mask & ~halt;
    endfunction

endpackage

// File: rtl/clkfo_activity_mon.sv
`timescale 1ns/1ps
module clkfo_activity_mon
    import clkfo_pkg::*;
#(
    parameter int unsigned LOSS_CYC  = LOSS_CYC_DEF,
    parameter int unsigned REC_EDGES = REC_EDGES_DEF,
    parameter int unsigned MAIN_DIV  = MAIN_DIV_DEF
) (
    input  logic        clk_bak,
    input  logic        clk_main,
    input  logic        rst,
    input  logic        active,
    output watch_stat_t status
);
    localparam int unsigned TW     = $clog2(LOSS_CYC + 1);
    localparam int unsigned RW     = $clog2(REC_EDGES + 1);
    localparam int unsigned SYNC_N = 3;
    localparam logic [TW-1:0] T_MAX = TW'(LOSS_CYC);
    localparam logic [TW-1:0] T_ONE = TW'(1);
    localparam logic [RW-1:0] R_MAX = RW'(REC_EDGES);
    localparam logic [RW-1:0] R_ONE = RW'(1);
    localparam logic [MAIN_DIV-1:0] M_ONE = MAIN_DIV'(1);

    // main domain: divided toggle so the backup domain can resolve it
    logic [MAIN_DIV-1:0] mdiv;
    always_ff @(posedge clk_main) begin
        if (rst) mdiv <= '0;
        else     mdiv <= mdiv + M_ONE;
    end

    // backup domain: synchronize toggle, detect a change
    logic [SYNC_N-1:0] s_q;
    logic              edge_seen;
    always_ff @(posedge clk_bak) begin
        if (rst) s_q <= '0;
        else     s_q <= {s_q[SYNC_N-2:0], mdiv[MAIN_DIV-1]};
    end
    assign edge_seen = s_q[SYNC_N-1] ^ s_q[SYNC_N-2];

    logic [TW-1:0] tcnt;
    logic [RW-1:0] rcnt;

    always_ff @(posedge clk_bak) begin
        if (rst || !active)  tcnt <= '0;
        else if (edge_seen)  tcnt <= '0;
        else if (tcnt != T_MAX) tcnt <= tcnt + T_ONE;
    end

    always_ff @(posedge clk_bak) begin
        if (rst)                            rcnt <= '0;
        else if (tcnt == T_MAX)             rcnt <= '0;
        else if (edge_seen && rcnt != R_MAX) rcnt <= rcnt + R_ONE;
    end

    always_comb begin
        status.lost    = (tcnt == T_MAX);
        status.healthy = (rcnt == R_MAX);
    end

    AST_TIMER_CAP: assert property (@(posedge clk_bak) disable iff (rst)
        tcnt <= T_MAX);                                            // R1
    AST_HEALTH_NEEDS_EDGE: assert property (@(posedge clk_bak) disable iff (rst)
        $rose(status.healthy) |-> $past(edge_seen));               // R2
    AST_NO_LOSS_WHEN_OFF: assert property (@(posedge clk_bak) disable iff (rst)
        !active |=> !status.lost);                                 // R9

endmodule

// File: rtl/clkfo_ctrl.sv
`timescale 1ns/1ps
module clkfo_ctrl
    import clkfo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  watch_stat_t status,
    input  logic        cfg_wr,
    input  clkfo_cfg_t  cfg_in,
    input  logic        irq_mask,
    input  logic        halt_mode,
    input  logic        wait_mode,
    input  logic        flag_clr,
    output logic        active,
    output logic        use_bak,
    output logic        flag,
    output logic        irq,
    output logic        wake
);
    clkfo_cfg_t cfg_q;
    clk_src_e   src_q;
    logic       flag_q;

    // configuration survives halt; only reset restores defaults
    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= CFG_RESET;
        else if (cfg_wr) cfg_q <= cfg_in;
    end

    assign active  = cfg_q.det_en & ~halt_mode;
    assign use_bak = (src_q == SRC_BAK);

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q <= SRC_MAIN;
        end else begin
            case (src_q)
                SRC_MAIN: if (status.lost && active) src_q <= SRC_BAK;
                SRC_BAK:  if (status.healthy)        src_q <= SRC_MAIN;
                default:  src_q <= SRC_MAIN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  flag_q <= 1'b0;
        else if (use_bak)         flag_q <= 1'b1;
        else if (flag_clr)        flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign irq  = irq_gate(cfg_q, flag_q, irq_mask, halt_mode);
    assign wake = irq & wait_mode;

    AST_SWITCH_NEEDS_LOSS: assert property (@(posedge clk) disable iff (rst)
        $rose(use_bak) |-> $past(status.lost));                    // R1
    AST_BACK_NEEDS_HEALTH: assert property (@(posedge clk) disable iff (rst)
        $fell(use_bak) |-> $past(status.healthy));                 // R2
    AST_FLAG_AFTER_SWITCH: assert property (@(posedge clk) disable iff (rst)
        use_bak |=> flag_q);                                       // R3
    AST_FLAG_KEPT_ON_BAK: assert property (@(posedge clk) disable iff (rst)
        (flag_q && use_bak) |=> flag_q);                           // R4
    AST_HALT_BLOCKS_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (halt_mode && !use_bak) |=> !use_bak);                     // R7

endmodule

// File: rtl/clkfo_gf_mux.sv
`timescale 1ns/1ps
module clkfo_gf_mux
    import clkfo_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic clk_a,
    input  logic clk_b,
    input  logic rst,
    input  logic sel_b,
    output logic clk_out
);
    logic [SYNC_STAGES-1:0] a_q;
    logic [SYNC_STAGES-1:0] b_q;
    logic en_a, en_b;

    // a dead main clock cannot retire its own enable: the select kills it
    assign en_a = a_q[SYNC_STAGES-1] & ~sel_b;
    assign en_b = b_q[SYNC_STAGES-1];

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(negedge clk_a) begin
                if (rst) a_q <= '0;
                else     a_q <= {a_q[SYNC_STAGES-2:0], ~sel_b & ~en_b};
            end
            always_ff @(negedge clk_b) begin
                if (rst) b_q <= '0;
                else     b_q <= {b_q[SYNC_STAGES-2:0], sel_b & ~en_a};
            end
        end else begin : g_single
            always_ff @(negedge clk_a) begin
                if (rst) a_q <= '0;
                else     a_q <= ~sel_b & ~en_b;
            end
            always_ff @(negedge clk_b) begin
                if (rst) b_q <= '0;
                else     b_q <= sel_b & ~en_a;
            end
        end
    endgenerate

    assign clk_out = (clk_a & en_a) | (clk_b & en_b);

    AST_EXCLUSIVE_EN: assert property (@(posedge clk_b) disable iff (rst)
        $onehot0({en_a, en_b}));                                   // R10

endmodule

// File: rtl/clk_failover.sv
`timescale 1ns/1ps
module clk_failover
    import clkfo_pkg::*;
#(
    parameter int unsigned LOSS_CYC    = LOSS_CYC_DEF,
    parameter int unsigned REC_EDGES   = REC_EDGES_DEF,
    parameter int unsigned MAIN_DIV    = MAIN_DIV_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
    input  logic clk_main,
    input  logic clk_bak,
    input  logic rst,
    input  logic cfg_wr,
    input  logic cfg_det_en,
    input  logic cfg_irq_en,
    input  logic irq_mask,
    input  logic halt_mode,
    input  logic wait_mode,
    input  logic flag_clr,
    output logic clk_sys,
    output logic on_backup,
    output logic loss_flag,
    output logic irq,
    output logic wake
);
    watch_stat_t stat;
    clkfo_cfg_t  cfg_in;
    logic        active;
    logic        use_bak;

    assign cfg_in = '{det_en: cfg_det_en, irq_en: cfg_irq_en};

    clkfo_activity_mon #(
        .LOSS_CYC (LOSS_CYC),
        .REC_EDGES(REC_EDGES),
        .MAIN_DIV (MAIN_DIV)
    ) u_mon (
        .clk_bak (clk_bak),
        .clk_main(clk_main),
        .rst     (rst),
        .active  (active),
        .status  (stat)
    );

    clkfo_ctrl u_ctrl (
        .clk      (clk_bak),
        .rst      (rst),
        .status   (stat),
        .cfg_wr   (cfg_wr),
        .cfg_in   (cfg_in),
        .irq_mask (irq_mask),
        .halt_mode(halt_mode),
        .wait_mode(wait_mode),
        .flag_clr (flag_clr),
        .active   (active),
        .use_bak  (use_bak),
        .flag     (loss_flag),
        .irq      (irq),
        .wake     (wake)
    );

    clkfo_gf_mux #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mux (
        .clk_a  (clk_main),
        .clk_b  (clk_bak),
        .rst    (rst),
        .sel_b  (use_bak),
        .clk_out(clk_sys)
    );

    assign on_backup = use_bak;

endmodule

// File: tb/sim_clk_failover.sv
`timescale 1ns/1ps
module sim_clk_failover;

    logic clk_main = 1'b0, clk_bak = 1'b0, rst = 1'b1;
    logic cfg_wr = 1'b0, cfg_det_en = 1'b0, cfg_irq_en = 1'b0;
    logic irq_mask = 1'b0, halt_mode = 1'b0, wait_mode = 1'b0, flag_clr = 1'b0;
    logic clk_sys, on_backup, loss_flag, irq, wake;
    logic main_run = 1'b1;

    int total = 0, bad = 0;

    clk_failover u0 (
        .clk_main(clk_main), .clk_bak(clk_bak), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_det_en(cfg_det_en), .cfg_irq_en(cfg_irq_en),
        .irq_mask(irq_mask), .halt_mode(halt_mode), .wait_mode(wait_mode),
        .flag_clr(flag_clr), .clk_sys(clk_sys), .on_backup(on_backup),
        .loss_flag(loss_flag), .irq(irq), .wake(wake)
    );

    always #10 clk_bak = ~clk_bak;                 // 50 MHz backup
    always #7 if (main_run || clk_main) clk_main = ~clk_main; // stops low

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk_bak);
        #1;
    endtask

    // ---------------- per-cycle reference model ----------------
    bit chk_on = 0;
    bit m_flag = 0, m_irq_en = 0;
    bit sel_p = 0, clr_p = 0, wr_p = 0, cirq_p = 0, rst_p = 1;

    always @(negedge clk_bak) begin
        bit exp_irq;
        if (rst_p) begin
            m_flag = 0; m_irq_en = 0;
        end else begin
            m_flag = sel_p | (m_flag & !(clr_p & !sel_p));
            if (wr_p) m_irq_en = cirq_p;
        end
        exp_irq = m_flag & m_irq_en & !irq_mask & !halt_mode;
        if (chk_on) begin
            check(loss_flag === m_flag, "R3/R4", "loss_flag", loss_flag, m_flag);
            check(irq === exp_irq, halt_mode ? "R7" : "R5", "irq", irq, exp_irq);
            check(wake === (exp_irq & wait_mode), "R6", "wake", wake, exp_irq & wait_mode);
        end
        sel_p = on_backup; clr_p = flag_clr; wr_p = cfg_wr;
        cirq_p = cfg_irq_en; rst_p = rst;
    end

    // ---------------- clock quality monitors (R10) ----------------
    bit mon_on = 0;
    realtime t_last = 0.0, min_w = 1000.0;
    int n_sys = 0, n_bak = 0, n_main = 0;

    always @(clk_sys) begin
        if (mon_on && ($realtime - t_last) < min_w) min_w = $realtime - t_last;
        t_last = $realtime;
    end
    always @(posedge clk_sys)  n_sys++;
    always @(posedge clk_bak)  n_bak++;
    always @(posedge clk_main) n_main++;

    task automatic count_cmp(input bit on_bak);
        int s0, r0, ds, dr;
        s0 = n_sys; r0 = on_bak ? n_bak : n_main;
        step(20);
        ds = n_sys - s0; dr = (on_bak ? n_bak : n_main) - r0;
        check(ds >= dr - 1 && ds <= dr + 1, "R10",
              on_bak ? "sys edges vs backup" : "sys edges vs main", ds, dr);
    endtask

    task automatic write_cfg(input bit det, input bit ie);
        cfg_det_en = det; cfg_irq_en = ie; cfg_wr = 1;
        step(1);
        cfg_wr = 0;
    endtask

    task automatic pulse_clr;
        flag_clr = 1; step(1); flag_clr = 0;
    endtask

    task automatic look(input string req, input string what, input int act, input int exp);
        @(negedge clk_bak);
        #1;
        check(act == exp, req, what, act, exp);
    endtask

    task automatic do_reset;
        mon_on = 0;
        rst = 1; step(6); rst = 0; step(4);
        mon_on = 1;
    endtask

    task automatic run_all;
        step(2);
        do_reset;
        chk_on = 1;
        @(negedge clk_bak);
        check(on_backup === 1'b0, "R12", "on_backup after reset", on_backup, 0);
        check(loss_flag === 1'b0, "R12", "loss_flag after reset", loss_flag, 0);
        check(irq === 1'b0, "R12", "irq after reset", irq, 0);
        step(1);
        count_cmp(0);                                  // R10 on main

        // R1: loss and switch
        write_cfg(1, 1);
        main_run = 0;
        step(6);
        @(negedge clk_bak); check(on_backup === 1'b0, "R1", "no switch before timeout", on_backup, 0);
        step(14);
        @(negedge clk_bak); check(on_backup === 1'b1, "R1", "switched to backup", on_backup, 1);
        step(2);
        @(negedge clk_bak); check(loss_flag === 1'b1, "R3", "flag set on backup", loss_flag, 1);
        step(1);
        count_cmp(1);                                  // R10 on backup

        // R4: clear ignored while on backup
        pulse_clr; step(1);
        @(negedge clk_bak); check(loss_flag === 1'b1, "R4", "clear ignored on backup", loss_flag, 1);

        // R6: wake in wait, gated by mask
        step(1); wait_mode = 1; step(1);
        @(negedge clk_bak); check(wake === 1'b1, "R6", "wake in wait", wake, 1);
        step(1); irq_mask = 1; step(1);
        @(negedge clk_bak); check(wake === 1'b0 && irq === 1'b0, "R5", "masked irq/wake", irq, 0);
        step(1); irq_mask = 0; wait_mode = 0;

        // R2: automatic return
        main_run = 1;
        step(12);
        @(negedge clk_bak); check(on_backup === 1'b1, "R2", "no early return", on_backup, 1);
        step(38);
        @(negedge clk_bak); check(on_backup === 1'b0, "R2", "returned to main", on_backup, 0);
        check(loss_flag === 1'b1, "R3", "flag sticky after return", loss_flag, 1);
        step(1);
        count_cmp(0);
        pulse_clr; step(1);
        @(negedge clk_bak); check(loss_flag === 1'b0, "R4", "clear on main", loss_flag, 0);

        // R11: short bursts keep backup
        step(1); main_run = 0; step(25);
        for (int k = 0; k < 5; k++) begin
            main_run = 1; step(3); main_run = 0; step(15);
            @(negedge clk_bak); check(on_backup === 1'b1, "R11", "burst keeps backup", on_backup, 1);
            step(1);
        end
        main_run = 1; step(50);
        @(negedge clk_bak); check(on_backup === 1'b0, "R2", "return after bursts", on_backup, 0);
        step(1); pulse_clr; step(2);

        // R7: halt disables detection
        halt_mode = 1; main_run = 0; step(25);
        @(negedge clk_bak); check(on_backup === 1'b0, "R7", "no switch in halt", on_backup, 0);
        check(irq === 1'b0 && wake === 1'b0, "R7", "silent in halt", irq, 0);
        step(1); main_run = 1; step(10); halt_mode = 0; step(5);

        // R8: configuration kept across halt
        main_run = 0; step(20);
        @(negedge clk_bak); check(on_backup === 1'b1, "R8", "detection kept after halt", on_backup, 1);
        step(2);
        @(negedge clk_bak); check(irq === 1'b1, "R8", "irq enable kept after halt", irq, 1);
        step(1); main_run = 1; step(50); pulse_clr; step(2);

        // R9: detection disabled
        write_cfg(0, 1);
        main_run = 0; step(25);
        @(negedge clk_bak); check(on_backup === 1'b0, "R9", "no switch when disabled", on_backup, 0);
        step(1); main_run = 1; step(10);

        // R8: reset restores defaults (detect on, irq off)
        do_reset;
        main_run = 0; step(25);
        @(negedge clk_bak); check(on_backup === 1'b1, "R8", "default detection on", on_backup, 1);
        check(irq === 1'b0, "R8", "default irq off", irq, 0);
        step(1); main_run = 1; step(50);
        @(negedge clk_bak); check(on_backup === 1'b0, "R2", "return after reset case", on_backup, 0);

        check(min_w >= 6.9, "R10", "min clk_sys phase (ps)", int'(min_w * 1000), 7000);
    endtask

    initial begin
        fork
            run_all();
            begin
                #200000;
                check(0, "WDOG", "watchdog expired", 1, 0);
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule